// File: doc/BRIEF.md
# External Bus Cycle Wait-State Controller

This block sequences one external memory access at a time for a 16-bit processor. An access is split into clock phases. T0 starts it, T1 follows, T2 repeats for as many wait phases as needed, and T3 ends it. Each phase lasts one clock. The block drives the active-low read strobe, the read/write direction line, the data-bus output enable and a read-data latch strobe. It holds the last read word on its own output.

Two sources can stretch an access, and the longer one wins:

- a 4-bit wait count taken from the bus control register at T0;
- an active-low acknowledge pin, sampled on every rising edge while an access is in flight.

The access ends only when the register count has run out and the acknowledge has been seen low on an earlier edge of the same access. A request presented during T3 starts the next access at once. The read strobe and direction line are released to high impedance whenever this device does not own the bus.

Top module: `xbw_ctrl`

## Requirements
- R1: While rst_ni is low and after its release with no request: done_o=0, latch_o=0, rd_no=1, rw_o=1, data_oe_o=0 and rdata_o=0.
- R2: An access runs T0, T1, one or more T2 phases, then T3, with one phase per clock. The shortest access is 4 clocks. done_o is 1 in the T3 phase only.
- R3: For a read (req_rd_i=1), rd_no is 0 from T1 through T3 and 1 in T0. For a write, rd_no stays 1 and data_oe_o is 1 from T1 through T3. data_oe_o is 0 for reads.
- R4: rw_o takes req_rd_i (1=read, 0=write) at the edge that enters T0. It holds that value through T3. It returns to 1 at the edge that enters idle.
- R5: On a read, rdata_o takes rdata_i at the edge that ends T3, and latch_o is 1 during that T3. rdata_o holds its value at all other times.
- R6: A register count N (wait_cnt_i, sampled at the edge ending T0) gives at least N extra T2 phases.
- R7: T2 repeats until the register count is zero and ack_ni has been sampled low on an earlier rising edge of the access. If ack_ni is first low during phase index p (T0=0), the access is max(4, N+4, p+3) clocks long.
- R8: ack_ni is ignored while no access is in progress: a low level during idle does not shorten the next access.
- R9: With master_i=0, req_i starts no access, and rd_oe_o and rw_oe_o are 0. With master_i=1, both are 1.
- R10: A request held during T3 makes the next clock T0 of a new access, with no idle phase between the two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one phase per period |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| master_i | input | 1 | This device owns the bus |
| wait_cnt_i | input | 4 | Register-programmed wait count |
| ack_ni | input | 1 | Active-low transfer acknowledge |
| rdata_i | input | 16 | Data bus input |
| rd_no | output | 1 | Active-low read strobe |
| rd_oe_o | output | 1 | Drive enable for the read strobe |
| rw_o | output | 1 | Direction line, 1 = read |
| rw_oe_o | output | 1 | Drive enable for the direction line |
| data_oe_o | output | 1 | Data bus output enable (writes) |
| latch_o | output | 1 | Read-data capture strobe |
| done_o | output | 1 | Access completes this phase |
| rdata_o | output | 16 | Last captured read word |

## Verification
Two events can land on the same edge: the register count reaching zero, and the acknowledge being sampled low for the first time. The bench provokes this with N=2 and the acknowledge going low in phase 3. It expects exactly 6 clocks, no extra phase from either source. A second collision is tested with a request held through T3 while one access ends and the next begins. That case must show done_o in T3, then rw_o of the new access on the very next clock with done_o low.

// File: rtl/xbw_pkg.sv
package xbw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T0   = 3'd1,
    PH_T1   = 3'd2,
    PH_T2   = 3'd3,
    PH_T3   = 3'd4
  } phase_e;
endpackage

// File: rtl/xbw_phase_fsm.sv
module xbw_phase_fsm
  import xbw_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   wait_done_i,
  output phase_e state_o,
  output phase_e state_nxt_o
);
  phase_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: if (start_i) state_d = PH_T0;
      PH_T0:   state_d = PH_T1;
      PH_T1:   state_d = PH_T2;
      PH_T2:   if (wait_done_i) state_d = PH_T3;
      PH_T3:   state_d = start_i ? PH_T0 : PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= PH_IDLE;
    else         state_q <= state_d;

  assign state_o     = state_q;
  assign state_nxt_o = state_d;
endmodule

// File: rtl/xbw_wait_merge.sv
module xbw_wait_merge
  import xbw_pkg::*;
#(
  parameter int unsigned WCW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  phase_e         state_i,
  input  logic [WCW-1:0] wait_cnt_i,
  input  logic           ack_ni,
  output logic [WCW-1:0] cnt_o,
  output logic           ack_seen_o,
  output logic           wait_done_o
);
  logic [WCW-1:0] cnt_q;
  logic           ack_q;

  // register count loaded leaving T0, runs down in T2
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                             cnt_q <= '0;
    else if (state_i == PH_T0)               cnt_q <= wait_cnt_i;
    else if (state_i == PH_T2 && cnt_q != 0) cnt_q <= cnt_q - 1'b1;

  // acknowledge only sampled inside an access
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                         ack_q <= 1'b0;
    else if (state_i == PH_IDLE || state_i == PH_T3)     ack_q <= 1'b0;
    else if (!ack_ni)                                    ack_q <= 1'b1;

  assign cnt_o       = cnt_q;
  assign ack_seen_o  = ack_q;
  assign wait_done_o = (cnt_q == '0) && ack_q;
endmodule

// File: rtl/xbw_strobes.sv
module xbw_strobes
  import xbw_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        state_i,
  input  phase_e        state_nxt_i,
  input  logic          req_rd_i,
  input  logic          master_i,
  input  logic [DW-1:0] rdata_i,
  output logic          rd_no,
  output logic          rw_o,
  output logic          data_oe_o,
  output logic          latch_o,
  output logic [DW-1:0] rdata_o
);
  logic          rw_q, rd_n_q;
  logic [DW-1:0] rdata_q;
  logic          in_xfer;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                       rw_q <= 1'b1;
    else if (state_nxt_i == PH_T0)     rw_q <= req_rd_i;
    else if (state_nxt_i == PH_IDLE)   rw_q <= 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                       rd_n_q <= 1'b1;
    else if (state_i == PH_T0 && rw_q)                 rd_n_q <= 1'b0;
    else if (state_i == PH_T3 || state_i == PH_IDLE)   rd_n_q <= 1'b1;

  assign latch_o = (state_i == PH_T3) && rw_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      rdata_q <= '0;
    else if (latch_o) rdata_q <= rdata_i;

  assign in_xfer   = (state_i == PH_T1) || (state_i == PH_T2) || (state_i == PH_T3);
  assign rd_no     = rd_n_q;
  assign rw_o      = rw_q;
  assign data_oe_o = master_i && !rw_q && in_xfer;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/xbw_ctrl.sv
module xbw_ctrl
  import xbw_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned WCW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           req_rd_i,
  input  logic           master_i,
  input  logic [WCW-1:0] wait_cnt_i,
  input  logic           ack_ni,
  input  logic [DW-1:0]  rdata_i,
  output logic           rd_no,
  output logic           rd_oe_o,
  output logic           rw_o,
  output logic           rw_oe_o,
  output logic           data_oe_o,
  output logic           latch_o,
  output logic           done_o,
  output logic [DW-1:0]  rdata_o
);
  phase_e         state_q, state_nxt;
  logic [WCW-1:0] wcnt;
  logic           ack_seen, wait_done, start;

  assign start = req_i && master_i;

  xbw_phase_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i     (start),
    .wait_done_i (wait_done),
    .state_o     (state_q),
    .state_nxt_o (state_nxt)
  );

  xbw_wait_merge #(.WCW(WCW)) u_wait (
    .clk_i, .rst_ni,
    .state_i     (state_q),
    .wait_cnt_i,
    .ack_ni,
    .cnt_o       (wcnt),
    .ack_seen_o  (ack_seen),
    .wait_done_o (wait_done)
  );

  xbw_strobes #(.DW(DW)) u_strb (
    .clk_i, .rst_ni,
    .state_i     (state_q),
    .state_nxt_i (state_nxt),
    .req_rd_i,
    .master_i,
    .rdata_i,
    .rd_no,
    .rw_o,
    .data_oe_o,
    .latch_o,
    .rdata_o
  );

  assign done_o  = (state_q == PH_T3);
  assign rd_oe_o = master_i;
  assign rw_oe_o = master_i;
endmodule

// File: rtl/xbw_ctrl_chk.sv
module xbw_ctrl_chk
  import xbw_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned WCW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input phase_e         state_q,
  input logic [WCW-1:0] wcnt,
  input logic           ack_seen,
  input logic           rd_no,
  input logic           rw_o,
  input logic           latch_o,
  input logic [DW-1:0]  rdata_o
);
  p_rw_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_T1 || state_q == PH_T2 || state_q == PH_T3) |-> $stable(rw_o));

  p_rd_only_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> rw_o);

  p_reg_waits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_T2 && wcnt != '0) |=> state_q == PH_T2);

  p_ack_needed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_T2 && !ack_seen) |=> state_q != PH_T3);

  p_rdata_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_o |=> $stable(rdata_o));

  p_idle_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_IDLE) |-> rd_no);
endmodule

bind xbw_ctrl xbw_ctrl_chk #(.DW(DW), .WCW(WCW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .state_q  (state_q),
  .wcnt     (wcnt),
  .ack_seen (ack_seen),
  .rd_no    (rd_no),
  .rw_o     (rw_o),
  .latch_o  (latch_o),
  .rdata_o  (rdata_o)
);

// File: tb/sim_xbw_ctrl.sv
module sim_xbw_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, req_rd_i = 1'b0, master_i = 1'b1, ack_ni = 1'b1;
  logic [3:0]  wait_cnt_i = '0;
  logic [15:0] rdata_i = '0;
  logic        rd_no, rd_oe_o, rw_o, rw_oe_o, data_oe_o, latch_o, done_o;
  logic [15:0] rdata_o;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xbw_ctrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // one access; ack low from phase p on; checks length, strobes, data
  task automatic run_access(input logic rd, input int n, input int p, input logic [15:0] d);
    int len = 0;
    int exp_len = imax(4, imax(n + 4, p + 3));
    @(negedge clk_i);
    req_i = 1'b1; req_rd_i = rd; wait_cnt_i = 4'(n); ack_ni = 1'b1;
    @(posedge clk_i);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk_i);
      req_i = 1'b0;
      ack_ni = (k >= p) ? 1'b0 : 1'b1;
      chk("R4 rw during access", 32'(rw_o), 32'(rd));
      if (k == 0) chk("R3 rd high in T0", 32'(rd_no), 32'd1);
      else begin
        chk("R3 rd strobe", 32'(rd_no), 32'(!rd));
        chk("R3 data_oe", 32'(data_oe_o), 32'(!rd));
      end
      if (done_o) begin
        len = k + 1;
        chk("R5 latch strobe", 32'(latch_o), 32'(rd));
        rdata_i = d;
        break;
      end
    end
    chk("R7 access length", 32'(len), 32'(exp_len));
    @(negedge clk_i);
    ack_ni = 1'b1;
    chk("R2 done only in T3", 32'(done_o), 32'd0);
    chk("R4 rw back to high", 32'(rw_o), 32'd1);
    chk("R3 rd released", 32'(rd_no), 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 done", 32'(done_o), 32'd0);
    chk("R1 rd", 32'(rd_no), 32'd1);
    chk("R1 rw", 32'(rw_o), 32'd1);
    chk("R1 data_oe", 32'(data_oe_o), 32'd0);
    chk("R1 rdata", 32'(rdata_o), 32'd0);
    chk("R1 latch", 32'(latch_o), 32'd0);
  endtask

  task automatic t_reads();
    run_access(1'b1, 0, 0, 16'hA5C3);
    chk("R5 read data", 32'(rdata_o), 32'hA5C3);
    run_access(1'b1, 3, 0, 16'h1234);
    chk("R6 read data N=3", 32'(rdata_o), 32'h1234);
    run_access(1'b1, 15, 0, 16'hFFFF);
    chk("R6 max count", 32'(rdata_o), 32'hFFFF);
  endtask

  task automatic t_writes();
    run_access(1'b0, 0, 0, 16'h0BAD);
    chk("R5 write keeps rdata", 32'(rdata_o), 32'hFFFF);
    run_access(1'b0, 1, 6, 16'h0000);
  endtask

  task automatic t_ack_merge();
    run_access(1'b1, 0, 3, 16'h0001);
    run_access(1'b1, 5, 2, 16'h0002);
    run_access(1'b1, 2, 3, 16'h0003); // count and ack meet on one edge
    chk("R7 coincident data", 32'(rdata_o), 32'h0003);
  endtask

  task automatic t_idle_ack();
    @(negedge clk_i); ack_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R8 idle ack no done", 32'(done_o), 32'd0);
    run_access(1'b1, 0, 4, 16'h0044); // expects 7 clocks
  endtask

  task automatic t_not_master();
    @(negedge clk_i); master_i = 1'b0; req_i = 1'b1; req_rd_i = 1'b1;
    repeat (4) begin
      @(negedge clk_i);
      chk("R9 no access", 32'(done_o | !rd_no), 32'd0);
      chk("R9 rd_oe", 32'(rd_oe_o), 32'd0);
      chk("R9 rw_oe", 32'(rw_oe_o), 32'd0);
    end
    req_i = 1'b0; master_i = 1'b1;
    @(negedge clk_i);
    chk("R9 oe back", 32'({rd_oe_o, rw_oe_o}), 32'd3);
  endtask

  task automatic t_back_to_back();
    @(negedge clk_i);
    req_i = 1'b1; req_rd_i = 1'b1; wait_cnt_i = '0; ack_ni = 1'b0;
    @(posedge clk_i);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      if (k == 3) begin req_rd_i = 1'b0; chk("R10 first done", 32'(done_o), 32'd1); end
      if (k == 4) begin
        chk("R10 no idle gap", 32'(done_o), 32'd0);
        chk("R10 new rw", 32'(rw_o), 32'd0);
        req_i = 1'b0;
      end
      if (k == 7) chk("R10 second done", 32'(done_o), 32'd1);
    end
    @(negedge clk_i); ack_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_reads();
    t_writes();
    t_ack_merge();
    t_idle_ack();
    t_not_master();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule